// File: doc/BRIEF.md
# FIFO-Loaded I2C Register Writer

This block is an I2C bus master that only writes. It is meant for peripherals that expose byte-wide registers. Before a transfer, software sets three values: a 7-bit device address, a one-byte register index, and a length field that holds the byte count minus one. It then pushes up to sixteen payload bytes into an internal queue. A single start command runs the whole write on the bus without further help: START, the address byte with the write flag, the register index, the queued bytes, and STOP.

The bus clock comes from two programmable dividers in series followed by a fixed divide-by-three stage. Each bus bit therefore takes three ticks of the second divider. A clock-enable command turns the dividers on. A soft-reset command returns everything to the power-up state, with the clock turned off. A busy output shows when a frame is on the wire. If the target does not acknowledge, the transfer stops, the queue is emptied and a sticky error flag is set.

Top module: `i2cw_writer`

## Requirements
- R1: After reset, scl_o and sda_o are 1, busy_o, start_o and err_o are 0, and level_o is 0. While the engine is idle, both bus lines stay released (1).
- R2: Each wdata_valid_i pulse adds one byte to the queue and raises level_o by one while level_o is below 16. A pulse at level 16 is dropped. Bytes leave the queue in the order they were written.
- R3: Once the clock is enabled, the SCL period is 3*D1*(div2_i+1) clock cycles, where D1 is div1_i, or 1 when div1_i is 0. Until a clk_en_i pulse arrives, the bus does not move, even with a pending start.
- R4: A frame is START (sda falls while scl is high), then the byte {dev_addr_i, 0}, then sub_addr_i, then len_m1_i+1 queued bytes, then STOP (sda rises while scl is high). Bytes are sent MSB first. Each byte is followed by a ninth clock with sda released for the acknowledge. No other sda change happens while scl is high.
- R5: A start_i pulse sets start_o. start_o stays high until the STOP ends and then clears in the same cycle that busy_o falls. busy_o is high from the START to the end of the STOP.
- R6: If sda is high at the acknowledge clock of any byte, STOP follows that acknowledge with no further byte sent. The queue is emptied (level_o 0), err_o goes to 1, and start_o clears after the STOP.
- R7: err_o stays 1 through later successful transfers until a soft reset.
- R8: A soft_rst_i pulse empties the queue, clears err_o and start_o, turns the clock off, and returns the bus to idle. A start_i in the same cycle as soft_rst_i is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| soft_rst_i | input | 1 | Soft-reset command pulse |
| clk_en_i | input | 1 | Clock-enable command pulse |
| start_i | input | 1 | Start command pulse |
| dev_addr_i | input | 7 | Target device address |
| sub_addr_i | input | 8 | Register index sent after the address |
| len_m1_i | input | 4 | Number of payload bytes minus one |
| wdata_i | input | 8 | Byte to queue |
| wdata_valid_i | input | 1 | Queue write strobe |
| div1_i | input | 8 | First divider (0 acts as 1) |
| div2_i | input | 8 | Second divider minus one |
| sda_i | input | 1 | Sampled SDA line |
| scl_o | output | 1 | SCL drive (1 = released) |
| sda_o | output | 1 | SDA drive (1 = released) |
| busy_o | output | 1 | Frame on the bus |
| start_o | output | 1 | Start command pending or running |
| err_o | output | 1 | Sticky no-acknowledge error |
| level_o | output | 5 | Queue fill level |

## Verification
A soft-reset command and a start command can arrive in the same clock, with the queue loaded and the clock enabled. The bench pulses both together and then reads start_o, level_o and err_o on the next falling edge. It also watches the bus for a few hundred cycles to confirm that no START appears, so the reset is seen to win. The bench also lets a queue write meet a full queue, and confirms that the dropped byte never reaches the wire.

// File: rtl/i2cw_pkg.sv
package i2cw_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_BIT,
    S_ACK,
    S_STOP
  } slot_e;
endpackage

// File: rtl/i2cw_clkdiv.sv
module i2cw_clkdiv #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [DIV_W-1:0] div1_i,
  input  logic [DIV_W-1:0] div2_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] c1_q, c2_q, d1_last;
  logic             m_tick;

  assign d1_last = (div1_i == '0) ? '0 : div1_i - 1'b1;
  assign m_tick  = en_i && (c1_q >= d1_last);
  assign tick_o  = m_tick && (c2_q >= div2_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      c1_q <= '0;
      c2_q <= '0;
    end else if (clr_i || !en_i) begin
      c1_q <= '0;
      c2_q <= '0;
    end else begin
      c1_q <= m_tick ? '0 : c1_q + 1'b1;
      if (m_tick) c2_q <= tick_o ? '0 : c2_q + 1'b1;
    end
  end
endmodule

// File: rtl/i2cw_fifo.sv
module i2cw_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         push_i,
  input  logic [W-1:0] din_i,
  input  logic         pop_i,
  output logic [W-1:0] head_o,
  output logic [AW:0]  level_o
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   lvl_q;
  logic          push_ok, pop_ok;

  assign push_ok = push_i && (lvl_q < (AW+1)'(DEPTH));
  assign pop_ok  = pop_i && (lvl_q != '0);
  assign head_o  = mem[rp_q];
  assign level_o = lvl_q;

  always_ff @(posedge clk_i) begin
    if (push_ok && !flush_i) mem[wp_q] <= din_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (push_ok) wp_q <= (wp_q == AW'(DEPTH-1)) ? '0 : wp_q + 1'b1;
      if (pop_ok)  rp_q <= (rp_q == AW'(DEPTH-1)) ? '0 : rp_q + 1'b1;
      lvl_q <= lvl_q + (AW+1)'(push_ok) - (AW+1)'(pop_ok);
    end
  end
endmodule

// File: rtl/i2cw_seq.sv
module i2cw_seq import i2cw_pkg::*; #(
  parameter int AW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          tick_i,
  input  logic          go_i,
  input  logic [6:0]    dev_addr_i,
  input  logic [7:0]    sub_addr_i,
  input  logic [AW-1:0] len_m1_i,
  input  logic [7:0]    fifo_data_i,
  input  logic          sda_i,
  output logic          scl_o,
  output logic          sda_o,
  output logic          busy_o,
  output logic          pop_o,
  output logic          done_o,
  output logic          abort_o
);
  slot_e       st_q;
  logic [1:0]  ph_q;
  logic [2:0]  bit_q;
  logic [7:0]  sh_q, sub_q;
  logic [AW:0] left_q;
  logic        sub_pend_q, nack_q, slot_end;

  assign slot_end = tick_i && (st_q != S_IDLE) && (ph_q == 2'd2);
  assign pop_o    = slot_end && (st_q == S_ACK) && !nack_q && !sub_pend_q && (left_q != '0);
  assign abort_o  = slot_end && (st_q == S_ACK) && nack_q;
  assign done_o   = slot_end && (st_q == S_STOP);
  assign busy_o   = (st_q != S_IDLE);

  always_comb begin
    unique case (st_q)
      S_START: begin scl_o = (ph_q != 2'd2); sda_o = (ph_q == 2'd0); end
      S_BIT:   begin scl_o = (ph_q == 2'd1); sda_o = sh_q[7];        end
      S_ACK:   begin scl_o = (ph_q == 2'd1); sda_o = 1'b1;           end
      S_STOP:  begin scl_o = (ph_q != 2'd0); sda_o = (ph_q == 2'd2); end
      default: begin scl_o = 1'b1;           sda_o = 1'b1;           end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; ph_q <= '0; bit_q <= '0; sh_q <= '0; sub_q <= '0;
      left_q <= '0; sub_pend_q <= 1'b0; nack_q <= 1'b0;
    end else if (clr_i) begin
      st_q <= S_IDLE; ph_q <= '0; left_q <= '0; sub_pend_q <= 1'b0; nack_q <= 1'b0;
    end else if (tick_i) begin
      if (st_q == S_IDLE) begin
        if (go_i) begin
          st_q       <= S_START;
          ph_q       <= '0;
          sh_q       <= {dev_addr_i, 1'b0};
          sub_q      <= sub_addr_i;
          left_q     <= {1'b0, len_m1_i} + 1'b1;
          sub_pend_q <= 1'b1;
        end
      end else if (ph_q != 2'd2) begin
        ph_q <= ph_q + 2'd1;
        if (st_q == S_ACK && ph_q == 2'd1) nack_q <= sda_i;  // sampled while scl high
      end else begin
        ph_q <= '0;
        unique case (st_q)
          S_START: begin st_q <= S_BIT; bit_q <= 3'd7; end
          S_BIT: begin
            if (bit_q == 3'd0) st_q <= S_ACK;
            else begin bit_q <= bit_q - 3'd1; sh_q <= {sh_q[6:0], 1'b0}; end
          end
          S_ACK: begin
            if (nack_q) st_q <= S_STOP;
            else if (sub_pend_q) begin
              sh_q <= sub_q; sub_pend_q <= 1'b0; st_q <= S_BIT; bit_q <= 3'd7;
            end else if (left_q != '0) begin
              sh_q <= fifo_data_i; left_q <= left_q - 1'b1; st_q <= S_BIT; bit_q <= 3'd7;
            end else st_q <= S_STOP;
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cw_writer.sv
module i2cw_writer #(
  parameter int FIFO_DEPTH = 16,
  parameter int DIV_W      = 8,
  localparam int AW        = $clog2(FIFO_DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             soft_rst_i,
  input  logic             clk_en_i,
  input  logic             start_i,
  input  logic [6:0]       dev_addr_i,
  input  logic [7:0]       sub_addr_i,
  input  logic [AW-1:0]    len_m1_i,
  input  logic [7:0]       wdata_i,
  input  logic             wdata_valid_i,
  input  logic [DIV_W-1:0] div1_i,
  input  logic [DIV_W-1:0] div2_i,
  input  logic             sda_i,
  output logic             scl_o,
  output logic             sda_o,
  output logic             busy_o,
  output logic             start_o,
  output logic             err_o,
  output logic [AW:0]      level_o
);
  logic       clk_en_q, start_q, err_q;
  logic       tick, pop, done, abort;
  logic [7:0] head;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      clk_en_q <= 1'b0;
      start_q  <= 1'b0;
      err_q    <= 1'b0;
    end else if (soft_rst_i) begin
      clk_en_q <= 1'b0;
      start_q  <= 1'b0;
      err_q    <= 1'b0;
    end else begin
      if (clk_en_i) clk_en_q <= 1'b1;
      start_q <= start_i | (start_q & ~done);
      if (abort) err_q <= 1'b1;
    end
  end

  i2cw_clkdiv #(.DIV_W(DIV_W)) i_div (
    .clk_i, .rst_ni, .clr_i(soft_rst_i), .en_i(clk_en_q),
    .div1_i, .div2_i, .tick_o(tick)
  );

  i2cw_fifo #(.DEPTH(FIFO_DEPTH), .W(8)) i_fifo (
    .clk_i, .rst_ni, .flush_i(soft_rst_i | abort),
    .push_i(wdata_valid_i & ~soft_rst_i), .din_i(wdata_i),
    .pop_i(pop), .head_o(head), .level_o
  );

  i2cw_seq #(.AW(AW)) i_seq (
    .clk_i, .rst_ni, .clr_i(soft_rst_i), .tick_i(tick), .go_i(start_q),
    .dev_addr_i, .sub_addr_i, .len_m1_i, .fifo_data_i(head), .sda_i,
    .scl_o, .sda_o, .busy_o, .pop_o(pop), .done_o(done), .abort_o(abort)
  );

  assign start_o = start_q;
  assign err_o   = err_q;
endmodule

// File: rtl/i2cw_checker.sv
module i2cw_checker #(
  parameter int DEPTH = 16,
  parameter int LW    = 5
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          soft_rst_i,
  input logic          clk_en_q,
  input logic          scl_o,
  input logic          sda_o,
  input logic          busy_o,
  input logic          start_o,
  input logic          err_o,
  input logic [LW-1:0] level_o
);
  p_idle_released_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (scl_o && sda_o));

  p_level_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= LW'(DEPTH));

  p_full_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (level_o == LW'(DEPTH) && !busy_o && !soft_rst_i) |=> level_o == LW'(DEPTH));

  p_scl_frozen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni || soft_rst_i)
    !clk_en_q |=> $stable(scl_o));

  p_start_clear_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(start_o) |-> !busy_o);

  p_nack_flush_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> level_o == '0);

  p_err_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !soft_rst_i) |=> err_o);

  p_soft_reset_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    soft_rst_i |=> (!start_o && !err_o && level_o == '0));
endmodule

bind i2cw_writer i2cw_checker #(.DEPTH(FIFO_DEPTH), .LW(AW+1)) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .soft_rst_i(soft_rst_i), .clk_en_q(clk_en_q),
  .scl_o(scl_o), .sda_o(sda_o), .busy_o(busy_o), .start_o(start_o),
  .err_o(err_o), .level_o(level_o)
);

// File: tb/test_i2cw_writer.sv
module test_i2cw_writer;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       soft_rst = 0, clk_en = 0, start = 0, wvalid = 0;
  logic [6:0] dev_addr = '0;
  logic [7:0] sub_addr = '0, wdata = '0, div1 = 8'd1, div2 = 8'd0;
  logic [3:0] len_m1 = '0;
  logic       scl, sda_o, sda_line, busy, start_st, err;
  logic [4:0] level;
  logic       ack_drv = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int n_start = 0, n_stop = 0, nbytes = 0, bitcnt = 0, rises = 0, t_rise1 = 0, period = 0;
  int nack_at = -1;
  bit sticky = 0;
  logic [7:0] got [24];
  logic [7:0] shb = '0;
  logic p_scl = 1'b1, p_sda = 1'b1;

  assign sda_line = sda_o & ~ack_drv;

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  i2cw_writer i_i2cw_writer (
    .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .clk_en_i(clk_en), .start_i(start),
    .dev_addr_i(dev_addr), .sub_addr_i(sub_addr), .len_m1_i(len_m1), .wdata_i(wdata),
    .wdata_valid_i(wvalid), .div1_i(div1), .div2_i(div2), .sda_i(sda_line),
    .scl_o(scl), .sda_o(sda_o), .busy_o(busy), .start_o(start_st), .err_o(err), .level_o(level)
  );

  // target model and bus monitor
  always @(negedge clk) begin
    logic s;
    s = sda_o & ~ack_drv;
    if (p_scl && scl && p_sda && !s) begin
      n_start = n_start + 1; n_stop = 0; nbytes = 0; bitcnt = 0; rises = 0;
    end else if (p_scl && scl && !p_sda && s) n_stop = n_stop + 1;
    if (!p_scl && scl) begin
      rises = rises + 1;
      if (rises == 1) t_rise1 = cyc;
      if (rises == 2) period = cyc - t_rise1;
      if (bitcnt < 8) begin
        shb = {shb[6:0], s};
        bitcnt = bitcnt + 1;
        if (bitcnt == 8) begin got[nbytes] = shb; nbytes = nbytes + 1; end
      end else bitcnt = 9;
    end
    if (p_scl && !scl) begin
      if (bitcnt == 8) ack_drv = ((nbytes - 1) != nack_at);
      else if (bitcnt == 9) begin ack_drv = 1'b0; bitcnt = 0; end
    end
    p_scl = scl;
    p_sda = s;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int i, input int len);
    return 8'((i * 29) + (len * 7) + 8'h13);
  endfunction

  task automatic pulse_clk_en();
    @(negedge clk) clk_en = 1; @(negedge clk) clk_en = 0;
  endtask

  task automatic pulse_soft();
    @(negedge clk) soft_rst = 1; @(negedge clk) soft_rst = 0;
  endtask

  task automatic push(input logic [7:0] v);
    @(negedge clk) begin wdata = v; wvalid = 1; end
    @(negedge clk) wvalid = 0;
  endtask

  task automatic launch(input int d1, input int d2, input int len, input int nk, input bit extra);
    div1 = 8'(d1); div2 = 8'(d2); nack_at = nk;
    dev_addr = 7'((len * 11 + d1 * 5 + 7'h21));
    sub_addr = 8'(8'hA0 + len + d2);
    len_m1 = 4'(len);
    for (int i = 0; i <= len; i++) push(pat(i, len));
    if (extra) push(8'hEE);
    chk(level == 5'(len + 1), "R2 level after load", level, len + 1);
    @(negedge clk) start = 1; @(negedge clk) start = 0;
  endtask

  task automatic finish_xfer(input int d1, input int d2, input int len, input int nk, input int st0);
    for (int i = 0; i < 20000; i++) begin @(negedge clk); if (n_start != st0) break; end
    chk(busy && start_st, "R5 busy and start during frame", {busy, start_st}, 3);
    for (int i = 0; i < 60000; i++) begin @(negedge clk); if (!start_st) break; end
    chk(!busy && scl && sda_o, "R5 idle after frame", {busy, scl, sda_o}, 3);
    chk(n_start == st0 + 1 && n_stop == 1, "R4 one START and one STOP", n_stop, 1);
    if (nk < 0) begin
      chk(nbytes == len + 3, "R4 byte count", nbytes, len + 3);
      chk(got[0] == {dev_addr, 1'b0}, "R4 address byte", got[0], {dev_addr, 1'b0});
      chk(got[1] == sub_addr, "R4 sub-address byte", got[1], sub_addr);
      for (int i = 0; i <= len; i++)
        chk(got[i + 2] == pat(i, len), "R2 R4 payload order", got[i + 2], pat(i, len));
      chk(period == 3 * ((d1 == 0) ? 1 : d1) * (d2 + 1), "R3 scl period", period,
          3 * ((d1 == 0) ? 1 : d1) * (d2 + 1));
      chk(err == sticky, "R7 error flag", err, sticky);
    end else begin
      sticky = 1;
      chk(nbytes == nk + 1, "R6 bytes before stop", nbytes, nk + 1);
      chk(err == 1'b1, "R6 error set", err, 1);
      chk(start_st == 1'b0, "R6 start cleared", start_st, 0);
    end
    chk(level == 0, "R6 R4 queue empty after frame", level, 0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    int st0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(scl && sda_o, "R1 bus released", {scl, sda_o}, 3);
    chk(!busy && !start_st && !err, "R1 flags clear", {busy, start_st, err}, 0);
    chk(level == 0, "R1 queue empty", level, 0);

    // clock disabled: pending start must not move the bus
    st0 = n_start;
    launch(1, 0, 0, -1, 0);
    repeat (300) @(negedge clk);
    chk(n_start == st0 && scl && !busy, "R3 no activity without clock enable", n_start - st0, 0);
    chk(start_st == 1'b1, "R5 start held pending", start_st, 1);
    pulse_clk_en();
    finish_xfer(1, 0, 0, -1, st0);

    // divider sweep
    for (int d1 = 0; d1 < 4; d1++)
      for (int d2 = 0; d2 < 3; d2++) begin
        st0 = n_start;
        launch(d1, d2, (d1 + d2) % 4, -1, 0);
        finish_xfer(d1, d2, (d1 + d2) % 4, -1, st0);
      end

    // length sweep
    for (int ln = 0; ln < 16; ln++) begin
      st0 = n_start;
      launch(1, 0, ln, -1, 0);
      finish_xfer(1, 0, ln, -1, st0);
    end

    // full queue: 17th write dropped
    st0 = n_start;
    div1 = 8'd1; div2 = 8'd0;
    for (int i = 0; i < 16; i++) push(pat(i, 15));
    push(8'hEE);
    chk(level == 16, "R2 write at full dropped", level, 16);
    dev_addr = 7'h3C; sub_addr = 8'h55; len_m1 = 4'd15; nack_at = -1;
    @(negedge clk) start = 1; @(negedge clk) start = 0;
    finish_xfer(1, 0, 15, -1, st0);

    // NACK at address, sub-address, data
    for (int k = 0; k < 3; k++) begin
      st0 = n_start;
      launch(2, 1, 3, (k == 2) ? 3 : k, 0);
      finish_xfer(2, 1, 3, (k == 2) ? 3 : k, st0);
    end
    // R7: good transfer keeps error
    st0 = n_start;
    launch(1, 1, 2, -1, 0);
    finish_xfer(1, 1, 2, -1, st0);

    pulse_soft();
    sticky = 0;
    chk(err == 0, "R8 soft reset clears error", err, 0);

    // R8: soft reset and start in the same cycle
    pulse_clk_en();
    for (int i = 0; i < 3; i++) push(pat(i, 2));
    st0 = n_start;
    @(negedge clk) begin soft_rst = 1; start = 1; end
    @(negedge clk) begin soft_rst = 0; start = 0; end
    chk(!start_st && level == 0 && !err, "R8 reset wins over start", {start_st, err}, 0);
    repeat (200) @(negedge clk);
    chk(n_start == st0 && scl && sda_o && !busy, "R8 bus stays idle", n_start - st0, 0);
    pulse_clk_en();
    repeat (50) @(negedge clk);
    chk(n_start == st0 && !start_st, "R8 start not retained", start_st, 0);

    summary();
  end
endmodule